// File: doc/BRIEF.md
# Programmable Pixel-Clock Divider with Blank-Gated Shift Clock

This block produces two clocks for the display side of a video pipeline, both timed by the pixel clock. The first is a divided clock whose ratio, one of four powers of two from 4 to 32, comes from a 2-bit select field. A new ratio is adopted only when the running period ends, so no shortened high or low phase ever reaches the output.

The second output is a gated copy of a video shift clock. The shift clock arrives as a slower clock derived from the pixel clock. It is passed through, registered by the pixel clock, while the active-low blank input is high. It is held low while video is blanked. The gate may only open or close while the incoming shift clock is low, so every pulse that leaves the block has full width.

Reset is asynchronous and active low. It is released synchronously through a two-stage synchronizer.

Top module: `pix_clk_divgate`

## Requirements
- R1: `div_clk_out` has a period of N pixel clocks, where N is 4, 8, 16 or 32 for `div_sel` = 00, 01, 10 or 11.
- R2: Each period of `div_clk_out` is low for N/2 cycles and then high for N/2 cycles, giving a 50% duty cycle.
- R3: A change of `div_sel` takes effect only when the current period ends. The period in progress keeps its old high and low lengths, and the next period uses the new ratio.
- R4: While `blank_n` is 1, `shift_clk_out` equals `shift_clk_in` delayed by one pixel clock, and every output pulse is as wide as its input pulse.
- R5: While `blank_n` is 0, `shift_clk_out` stays low once any pulse already in progress has completed.
- R6: The gate changes state only while `shift_clk_in` is low. If blank begins during a high shift pulse, that pulse still leaves the block in full. If blank ends during a high shift pulse, that pulse is dropped entirely.
- R7: While `rst_n` is low, both outputs are 0 and the divider counter is held at zero. After release, the first period uses divide-by-4 whatever `div_sel` is, and `div_sel` is adopted at the first period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Divide select: 00=/4, 01=/8, 10=/16, 11=/32 |
| shift_clk_in | input | 1 | Video shift clock, synchronous to clk_pix |
| blank_n | input | 1 | Blank, active low |
| div_clk_out | output | 1 | Divided clock, 50% duty |
| shift_clk_out | output | 1 | Shift clock gated by blank |

## Verification
The bench switches the ratio from 32 to 4 in the middle of a high phase. A divider that switched at once would cut that phase short of 16 cycles. It checks the period immediately after reset with divide-by-32 already selected. A design that loaded the select during reset would show a 16-cycle high phase there instead of 2. For the gate, the bench moves blank on the very cycle the shift clock rises, in both directions. A gate that followed blank without regard to the shift clock's level would either cut that pulse to one cycle or pass a partial pulse. The bench also checks the one-cycle alignment of the gated shift clock while video is active.

// File: rtl/vdg_pkg.sv
package vdg_pkg;

  // Width of the divide select field and log2 of the smallest ratio
  localparam int VDG_SEL_W     = 2;
  localparam int VDG_MIN_SHIFT = 2;

  // Named ratio codes (code i selects 2**(VDG_MIN_SHIFT+i))
  typedef enum logic [VDG_SEL_W-1:0] {
    RATIO_DIV4  = 2'b00,
    RATIO_DIV8  = 2'b01,
    RATIO_DIV16 = 2'b10,
    RATIO_DIV32 = 2'b11
  } ratio_e;

  // Shift clock gate state
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;

endpackage

// File: rtl/vdg_rst_sync.sv
module vdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vdg_ratio_divider.sv
module vdg_ratio_divider #(
  parameter int SEL_W     = 2,
  parameter int MIN_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             div_clk
);

  localparam int NUM_RATIO = 1 << SEL_W;
  localparam int CNT_W     = MIN_SHIFT + NUM_RATIO - 1;

  // Per-ratio terminal count and half period
  logic [CNT_W-1:0] term_tab [NUM_RATIO];
  logic [CNT_W-1:0] half_tab [NUM_RATIO];

  for (genvar gi = 0; gi < NUM_RATIO; gi++) begin : g_ratio
    assign term_tab[gi] = CNT_W'((1 << (MIN_SHIFT + gi)) - 1);
    assign half_tab[gi] = CNT_W'(1 << (MIN_SHIFT + gi - 1));
  end

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] ratio_q, ratio_d;
  logic             div_q, div_d;
  logic             wrap;
  logic             ratio_en;

  // Next state
  always_comb begin
    wrap     = (cnt_q == term_tab[ratio_q]);
    ratio_en = wrap;
    ratio_d  = ratio_en ? sel : ratio_q;
    cnt_d    = wrap ? '0 : cnt_q + CNT_W'(1);
    div_d    = (cnt_d >= half_tab[ratio_d]);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      div_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      if (ratio_en) begin
        ratio_q <= ratio_d;
      end
    end
  end

  assign div_clk = div_q;

  // The ratio in use never changes before the period ends
  assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));

  // The counter stays inside the current period
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_tab[ratio_q]);

  // The output falls exactly when a new period starts
  assert_fall_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_q) |-> (cnt_q == '0));

  // The output rises exactly at the half period
  assert_rise_at_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> (cnt_q == half_tab[ratio_q]));

endmodule

// File: rtl/vdg_shift_gate.sv
module vdg_shift_gate
  import vdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic blank_n,
  output logic sck_out
);

  gate_e en_q, en_d;
  logic  en_load;
  logic  out_q, out_d;

  // Next state: the gate may only move while the shift clock is low
  always_comb begin
    en_load = !sck_in;
    en_d    = en_load ? (blank_n ? GATE_OPEN : GATE_SHUT) : en_q;
    out_d   = sck_in && (en_d == GATE_OPEN);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= GATE_SHUT;
      out_q <= 1'b0;
    end else begin
      if (en_load) begin
        en_q <= en_d;
      end
      out_q <= out_d;
    end
  end

  assign sck_out = out_q;

  // The gate state only moves when the shift clock was low
  assert_gate_move_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> !$past(sck_in));

  // An output rise always follows a high input one cycle earlier
  assert_rise_follows_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(sck_in));

  // A shut gate passes nothing
  assert_shut_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == GATE_SHUT) |-> !out_q);

endmodule

// File: rtl/pix_clk_divgate.sv
module pix_clk_divgate
  import vdg_pkg::*;
#(
  parameter int SEL_W     = VDG_SEL_W,
  parameter int MIN_SHIFT = VDG_MIN_SHIFT,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             shift_clk_in,
  input  logic             blank_n,
  output logic             div_clk_out,
  output logic             shift_clk_out
);

  logic rst_n_int;

  vdg_rst_sync #(
    .STAGES (SYNC_LEN)
  ) u_rst_sync (
    .clk        (clk_pix),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vdg_ratio_divider #(
    .SEL_W     (SEL_W),
    .MIN_SHIFT (MIN_SHIFT)
  ) u_divider (
    .clk     (clk_pix),
    .rst_n   (rst_n_int),
    .sel     (div_sel),
    .div_clk (div_clk_out)
  );

  vdg_shift_gate u_gate (
    .clk     (clk_pix),
    .rst_n   (rst_n_int),
    .sck_in  (shift_clk_in),
    .blank_n (blank_n),
    .sck_out (shift_clk_out)
  );

endmodule

// File: tb/pix_clk_divgate_bench.sv
`timescale 1ns/1ps
module pix_clk_divgate_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       shift_in = 1'b0;
  logic       blank_n = 1'b1;
  logic       div_out;
  logic       shift_out;

  int n_tests = 0;
  int n_fail  = 0;
  int ph = 0;
  int mon_run = 0, mon_pulses = 0, mon_min = 1000, mon_max = 0;

  // Divide select codes and their ratios, walked by one loop (R1, R2)
  localparam int VEC_SEL [4] = '{1, 3, 0, 2};
  localparam int VEC_N   [4] = '{8, 32, 4, 16};

  always #10 clk = ~clk;

  pix_clk_divgate u_pix_clk_divgate (
    .clk_pix       (clk_pix_w),
    .rst_n         (rst_n),
    .div_sel       (div_sel),
    .shift_clk_in  (shift_in),
    .blank_n       (blank_n),
    .div_clk_out   (div_out),
    .shift_clk_out (shift_out)
  );

  wire clk_pix_w = clk;

  // Pulse-width monitor for the gated shift clock, sampled mid-cycle
  always @(posedge clk) begin
    #5;
    if (shift_out) begin
      mon_run++;
    end else if (mon_run > 0) begin
      mon_pulses++;
      if (mon_run < mon_min) mon_min = mon_run;
      if (mon_run > mon_max) mon_max = mon_run;
      mon_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    mon_run = 0; mon_pulses = 0; mon_min = 1000; mon_max = 0;
  endtask

  // One pixel clock of shift stimulus: 2 low, 2 high
  task automatic sh_step(input bit chk, input int exp, input string req);
    @(negedge clk);
    if (chk) check(shift_out == exp, req, int'(shift_out), exp);
    ph++;
    shift_in = ph[1];
  endtask

  // Align to a rising edge of div_out and measure high then low run
  task automatic meas(output int hi, output int lo);
    int prev;
    int guard;
    prev = int'(div_out);
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if ((prev == 0 && div_out) || guard > 200) break;
      prev = int'(div_out);
    end
    hi = 1;
    @(negedge clk);
    while (div_out && hi < 100) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!div_out && lo < 100) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi, lo;

    // R7: outputs low in reset even with the shift clock toggling
    div_sel = 2'b11;
    blank_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      shift_in = k[0];
      check(div_out == 1'b0, "R7 div in reset", int'(div_out), 0);
      check(shift_out == 1'b0, "R7 shift in reset", int'(shift_out), 0);
    end
    shift_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R7: first period is /4, then /32 selected before release is adopted (R3)
    meas(hi, lo);
    check(hi == 2, "R7 first high after reset", hi, 2);
    check(lo == 16, "R3 low after first wrap", lo, 16);

    // R1, R2: vector table of ratios
    for (int i = 0; i < 4; i++) begin
      div_sel = 2'(VEC_SEL[i]);
      repeat (70) @(negedge clk);
      meas(hi, lo);
      check(hi == VEC_N[i] / 2, "R2 high half", hi, VEC_N[i] / 2);
      check(lo == VEC_N[i] / 2, "R2 low half", lo, VEC_N[i] / 2);
      check(hi + lo == VEC_N[i], "R1 period", hi + lo, VEC_N[i]);
    end

    // R3: switch /32 -> /4 in the middle of a high phase
    div_sel = 2'b11;
    repeat (70) @(negedge clk);
    meas(hi, lo);
    hi = 1;
    repeat (4) begin @(negedge clk); hi++; end
    div_sel = 2'b00;
    @(negedge clk);
    while (div_out && hi < 100) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!div_out && lo < 100) begin lo++; @(negedge clk); end
    check(hi == 16, "R3 old high kept", hi, 16);
    check(lo == 2, "R3 new low", lo, 2);

    // R4: one-cycle copy while active
    blank_n = 1'b1;
    repeat (8) sh_step(1'b0, 0, "");
    for (int k = 0; k < 16; k++) sh_step(1'b1, int'(shift_in), "R4 delayed copy");
    clear_stats();
    repeat (40) sh_step(1'b0, 0, "");
    check(mon_pulses >= 9, "R4 pulse count", mon_pulses, 9);
    check(mon_min == 2, "R4 min width", mon_min, 2);
    check(mon_max == 2, "R4 max width", mon_max, 2);

    // R5: silent during blank
    blank_n = 1'b0;
    repeat (4) sh_step(1'b0, 0, "");
    clear_stats();
    for (int k = 0; k < 40; k++) sh_step(1'b1, 0, "R5 held low");
    check(mon_pulses == 0, "R5 no pulses", mon_pulses, 0);

    // R6: blank starts as the shift clock rises -> full pulse, then none
    blank_n = 1'b1;
    repeat (8) sh_step(1'b0, 0, "");
    do sh_step(1'b0, 0, ""); while (ph % 4 != 2);
    blank_n = 1'b0;
    clear_stats();
    repeat (12) sh_step(1'b0, 0, "");
    check(mon_pulses == 1, "R6 one pulse at blank start", mon_pulses, 1);
    check(mon_max == 2, "R6 full width at blank start", mon_max, 2);

    // R6: blank ends as the shift clock rises -> pulse dropped, later full
    do sh_step(1'b0, 0, ""); while (ph % 4 != 2);
    blank_n = 1'b1;
    clear_stats();
    sh_step(1'b1, 0, "R6 partial pulse dropped");
    sh_step(1'b1, 0, "R6 partial pulse dropped");
    repeat (14) sh_step(1'b0, 0, "");
    check(mon_pulses >= 2, "R6 pulses resume", mon_pulses, 2);
    check(mon_min == 2, "R6 resumed min width", mon_min, 2);
    check(mon_max == 2, "R6 resumed max width", mon_max, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule